// File: doc/BRIEF.md
# Directional Deringing Pixel Filter

This block is the arithmetic core of a directional deringing filter. For each output pixel it takes the centre sample and twelve neighbour samples. Upstream logic has already picked these samples along an estimated edge direction: two primary taps and four secondary taps in each of two tap rounds. It also takes a primary strength, a secondary strength and a damping value. Every neighbour difference passes through a damping-driven nonlinearity that suppresses large steps, so real edges are preserved while small ringing ripples are pulled toward the centre. The weighted sum is rounded with a sign correction, added to the centre and clamped to the range spanned by the samples that were read.

Samples are 16 bits wide. The code 0x8000 marks a padding position outside the picture. The min/max tracking is built so that such a code never widens the clamp window. The block is a fixed-latency pipeline that accepts one pixel per clock. A valid flag travels alongside the data. Sample fetch and direction search sit outside the block.

Top module: `dering_pixel_filter`

## Requirements
- R1: For each tap, with d = tap − centre (unsigned operands), the block uses c = sign(d)·min(|d|, max(0, t − (|d| >> s))), where t is the strength and s the shift for that tap class.
- R2: Primary shift = max(0, damping − floor_log2(primary strength)). Secondary shift = damping − floor_log2(secondary strength), saturated at 0. floor_log2(0) is taken as 0.
- R3: Primary taps are `pri_taps` slices 0..3 (slice i at bits [16i+15:16i]). Slices 0,1 form round 0 and use weight w0 = 4 − (strength & 1). Slices 2,3 form round 1 and use (w0 & 3) | 2.
- R4: Secondary taps are `sec_taps` slices 0..7. Slices 0..3 form round 0 and use weight 2. Slices 4..7 form round 1 and use weight 1.
- R5: With sum the weighted total, the offset added to the centre is (sum − (sum<0) + 8) >> 4, using an arithmetic shift. So sum = −8 gives −1 and sum = +8 gives +1.
- R6: The result is clamped to [lo, hi]. lo and hi are derived from the centre and all twelve taps.
- R7: lo is the unsigned minimum, so a 0x8000 tap never becomes lo.
- R8: hi is the maximum with each tap read as signed 16-bit, so a 0x8000 tap never becomes hi.
- R9: A 0x8000 tap whose shifted magnitude reaches the strength contributes nothing to the sum.
- R10: A strength of zero makes every tap of that class contribute nothing.
- R11: `out_pix` is the low 8 bits of the clamped result.
- R12: One pixel per cycle. `out_valid` equals `in_valid` from three rising edges earlier. Synchronous reset (`rst_n` low) clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| centre | input | 16 | Centre sample |
| pri_taps | input | 64 | Four primary tap samples |
| sec_taps | input | 128 | Eight secondary tap samples |
| pri_str | input | 8 | Primary strength |
| sec_str | input | 8 | Secondary strength |
| damping | input | 4 | Damping |
| out_valid | output | 1 | Result present |
| out_pix | output | 8 | Filtered pixel |

## Verification
The bench targets several distinct faults:
- Sums of exactly −8 and +8: a design that drops the sign correction returns the centre instead of one step below it.
- Padding codes mixed with steep, strong taps that push the result past the window: signed min tracking or unsigned max tracking lets the output escape to 88 or 112 instead of stopping at 90 or 110.
- Isolated round-1 taps: swapped round weights show up as a result one step off.
- Secondary strength above the damping: a shift that wraps instead of saturating yields 101 instead of 100.
- Timing: latency, single-cycle valid pulses and a mid-stream reset.

// File: rtl/dering_pkg.sv
// Shared constants and helpers for the deringing pixel filter.
// Assumes two tap rounds, two primary and four secondary taps per round.
package dering_pkg;
    localparam int PRI_PER_ROUND = 2;
    localparam int SEC_PER_ROUND = 4;
    localparam int N_ROUNDS      = 2;
    localparam int N_PRI         = PRI_PER_ROUND * N_ROUNDS;
    localparam int N_SEC         = SEC_PER_ROUND * N_ROUNDS;
    localparam int N_TAPS        = N_PRI + N_SEC;
    localparam int WT_W          = 3;
    localparam int RND_SHIFT     = 4;
    localparam int RND_BIAS      = 8;
    localparam int PIPE_DEPTH    = 3;

    // Index of highest set bit; zero input yields zero.
    function automatic int unsigned floor_log2(input logic [31:0] v);
        int unsigned r;
        r = 0;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) r = b;
        end
        return r;
    endfunction

    // Damping minus log term, saturated at zero.
    function automatic int unsigned sat_shift(input int unsigned damp,
                                              input int unsigned lg);
        return (damp > lg) ? (damp - lg) : 0;
    endfunction

    // Primary tap weight for a round, from strength parity.
    function automatic logic [WT_W-1:0] pri_weight(input logic odd,
                                                   input int unsigned rnd);
        logic [WT_W-1:0] w0;
        w0 = odd ? 3'd3 : 3'd4;
        return (rnd == 0) ? w0 : ((w0 & 3'd3) | 3'd2);
    endfunction

    // Secondary tap weight for a round.
    function automatic logic [WT_W-1:0] sec_weight(input int unsigned rnd);
        return (rnd == 0) ? 3'd2 : 3'd1;
    endfunction
endpackage

// File: rtl/dering_constrain.sv
// Constrain nonlinearity for one tap: signed difference to the centre,
// magnitude limited by strength minus the damped magnitude.
// Assumes STR_W <= SAMP_W; purely combinational.
module dering_constrain #(
    parameter int SAMP_W = 16,
    parameter int STR_W  = 8,
    parameter int SH_W   = 4
) (
    input  logic [SAMP_W-1:0]      tap,
    input  logic [SAMP_W-1:0]      centre,
    input  logic [STR_W-1:0]       strength,
    input  logic [SH_W-1:0]        shift,
    output logic signed [STR_W:0]  con
);
    localparam int DW = SAMP_W + 1;

    logic signed [DW-1:0] diff;
    logic                 neg;
    logic [DW-1:0]        mag_d;
    logic [DW-1:0]        scaled;
    logic [DW-1:0]        str_x;
    logic [STR_W-1:0]     clip;
    logic [STR_W-1:0]     mag;

    // Difference, damping and magnitude limit.
    always_comb begin
        diff   = $signed({1'b0, tap}) - $signed({1'b0, centre});
        neg    = diff[DW-1];
        mag_d  = neg ? $unsigned(-diff) : $unsigned(diff);
        scaled = mag_d >> shift;
        str_x  = DW'(strength);
        clip   = (scaled >= str_x) ? '0 : STR_W'(str_x - scaled);
        mag    = (mag_d < DW'(clip)) ? STR_W'(mag_d) : clip;
        con    = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/dering_minmax.sv
// Clamp window over centre and taps: unsigned minimum, signed maximum,
// so a padding code (sign bit only) never widens the window.
// Purely combinational.
module dering_minmax #(
    parameter int SAMP_W = 16,
    parameter int N      = 12
) (
    input  logic [SAMP_W-1:0]   centre,
    input  logic [N*SAMP_W-1:0] taps,
    output logic [SAMP_W-1:0]   lo,
    output logic [SAMP_W-1:0]   hi
);
    logic [SAMP_W-1:0] s;

    // Fold every tap into the running bounds.
    always_comb begin
        lo = centre;
        hi = centre;
        s  = '0;
        for (int i = 0; i < N; i++) begin
            s = taps[i*SAMP_W +: SAMP_W];
            if (s < lo) lo = s;
            if ($signed(s) > $signed(hi)) hi = s;
        end
    end
endmodule

// File: rtl/dering_round_clamp.sv
// Sign-corrected rounding of the weighted sum, addition to the centre
// and clamp to the window. lo is unsigned, hi is signed.
// Assumes RES_W exceeds both ACC_W and SAMP_W by at least one bit.
module dering_round_clamp
    import dering_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int SAMP_W = 16,
    parameter int RES_W  = 18
) (
    input  logic signed [ACC_W-1:0] sum,
    input  logic [SAMP_W-1:0]       centre,
    input  logic [SAMP_W-1:0]       lo,
    input  logic [SAMP_W-1:0]       hi,
    output logic signed [RES_W-1:0] res
);
    logic signed [RES_W-1:0] sum_x, neg_x, bias_x, adj, cen_x, lo_x, hi_x, val;

    // Round, offset and clamp.
    always_comb begin
        sum_x  = {{(RES_W-ACC_W){sum[ACC_W-1]}}, sum};
        neg_x  = {{(RES_W-1){1'b0}}, sum[ACC_W-1]};
        bias_x = RES_W'(RND_BIAS);
        adj    = (sum_x - neg_x + bias_x) >>> RND_SHIFT;
        cen_x  = {{(RES_W-SAMP_W){1'b0}}, centre};
        lo_x   = {{(RES_W-SAMP_W){1'b0}}, lo};
        hi_x   = {{(RES_W-SAMP_W){hi[SAMP_W-1]}}, hi};
        val    = cen_x + adj;
        if (val < lo_x)      res = lo_x;
        else if (val > hi_x) res = hi_x;
        else                 res = val;
    end
endmodule

// File: rtl/dering_pixel_filter.sv
// Directional deringing filter, one pixel per clock, three-stage pipeline:
//   stage 1: constrain all taps, build the clamp window
//   stage 2: weight and accumulate
//   stage 3: round, offset, clamp
// Assumes the centre sample is a real pixel (below 0x8000).
module dering_pixel_filter
    import dering_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int STR_W  = 8,
    parameter int DAMP_W = 4,
    parameter int ACC_W  = 16,
    parameter int OUT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMP_W-1:0]       centre,
    input  logic [N_PRI*SAMP_W-1:0] pri_taps,
    input  logic [N_SEC*SAMP_W-1:0] sec_taps,
    input  logic [STR_W-1:0]        pri_str,
    input  logic [STR_W-1:0]        sec_str,
    input  logic [DAMP_W-1:0]       damping,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_pix
);
    localparam int CON_W = STR_W + 1;
    localparam int RES_W = ((ACC_W > SAMP_W) ? ACC_W : SAMP_W) + 2;

    // ---------------- stage 0: shifts and constrain ----------------
    logic [DAMP_W-1:0]       pri_shift, sec_shift;
    logic signed [CON_W-1:0] pri_con [N_PRI];
    logic signed [CON_W-1:0] sec_con [N_SEC];
    logic [SAMP_W-1:0]       win_lo, win_hi;

    // Per-class shift from damping and strength magnitude.
    always_comb begin
        pri_shift = DAMP_W'(sat_shift(32'(damping), floor_log2(32'(pri_str))));
        sec_shift = DAMP_W'(sat_shift(32'(damping), floor_log2(32'(sec_str))));
    end

    for (genvar g = 0; g < N_PRI; g++) begin : g_pri
        dering_constrain #(.SAMP_W(SAMP_W), .STR_W(STR_W), .SH_W(DAMP_W)) u_con (
            .tap      (pri_taps[g*SAMP_W +: SAMP_W]),
            .centre   (centre),
            .strength (pri_str),
            .shift    (pri_shift),
            .con      (pri_con[g])
        );
        a_r1_pri_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (pri_con[g] <= $signed({1'b0, pri_str}) &&
                          pri_con[g] >= -$signed({1'b0, pri_str})));
    end

    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        dering_constrain #(.SAMP_W(SAMP_W), .STR_W(STR_W), .SH_W(DAMP_W)) u_con (
            .tap      (sec_taps[g*SAMP_W +: SAMP_W]),
            .centre   (centre),
            .strength (sec_str),
            .shift    (sec_shift),
            .con      (sec_con[g])
        );
        a_r1_sec_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (sec_con[g] <= $signed({1'b0, sec_str}) &&
                          sec_con[g] >= -$signed({1'b0, sec_str})));
    end

    dering_minmax #(.SAMP_W(SAMP_W), .N(N_TAPS)) u_win (
        .centre (centre),
        .taps   ({sec_taps, pri_taps}),
        .lo     (win_lo),
        .hi     (win_hi)
    );

    // ---------------- stage 1 registers ----------------
    logic                    s1_vld, s1_odd;
    logic signed [CON_W-1:0] s1_pri [N_PRI];
    logic signed [CON_W-1:0] s1_sec [N_SEC];
    logic [SAMP_W-1:0]       s1_cen, s1_lo, s1_hi;

    // Capture constrained taps, window and strength parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_odd <= 1'b0;
            s1_cen <= '0;
            s1_lo  <= '0;
            s1_hi  <= '0;
            for (int i = 0; i < N_PRI; i++) s1_pri[i] <= '0;
            for (int i = 0; i < N_SEC; i++) s1_sec[i] <= '0;
        end else begin
            s1_vld <= in_valid;
            s1_odd <= pri_str[0];
            s1_cen <= centre;
            s1_lo  <= win_lo;
            s1_hi  <= win_hi;
            for (int i = 0; i < N_PRI; i++) s1_pri[i] <= pri_con[i];
            for (int i = 0; i < N_SEC; i++) s1_sec[i] <= sec_con[i];
        end
    end

    // R7: with a real centre the minimum can never rise above it.
    a_r7_lo_below_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_cen[SAMP_W-1]) |-> (s1_lo <= s1_cen));
    // R8: the maximum is never a padding code and never below the centre.
    a_r8_hi_not_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_cen[SAMP_W-1]) |->
            (!s1_hi[SAMP_W-1] && $signed(s1_hi) >= $signed(s1_cen)));

    // ---------------- stage 2: weighting ----------------
    logic signed [ACC_W-1:0] pri_term [N_PRI];
    logic signed [ACC_W-1:0] sec_term [N_SEC];
    logic signed [ACC_W-1:0] acc;

    for (genvar g = 0; g < N_PRI; g++) begin : g_pw
        assign pri_term[g] = ACC_W'(s1_pri[g]) *
            $signed(ACC_W'(pri_weight(s1_odd, g / PRI_PER_ROUND)));
    end

    for (genvar g = 0; g < N_SEC; g++) begin : g_sw
        assign sec_term[g] = ACC_W'(s1_sec[g]) *
            $signed(ACC_W'(sec_weight(g / SEC_PER_ROUND)));
    end

    // Accumulate all weighted terms.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N_PRI; i++) acc = acc + pri_term[i];
        for (int i = 0; i < N_SEC; i++) acc = acc + sec_term[i];
    end

    logic                    s2_vld;
    logic signed [ACC_W-1:0] s2_sum;
    logic [SAMP_W-1:0]       s2_cen, s2_lo, s2_hi;

    // Capture sum and carry the window forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_sum <= '0;
            s2_cen <= '0;
            s2_lo  <= '0;
            s2_hi  <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_sum <= acc;
            s2_cen <= s1_cen;
            s2_lo  <= s1_lo;
            s2_hi  <= s1_hi;
        end
    end

    // ---------------- stage 3: round and clamp ----------------
    logic signed [RES_W-1:0] res, s3_res;
    logic                    s3_vld;

    dering_round_clamp #(.ACC_W(ACC_W), .SAMP_W(SAMP_W), .RES_W(RES_W)) u_rc (
        .sum    (s2_sum),
        .centre (s2_cen),
        .lo     (s2_lo),
        .hi     (s2_hi),
        .res    (res)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_vld <= 1'b0;
            s3_res <= '0;
        end else begin
            s3_vld <= s2_vld;
            s3_res <= res;
        end
    end

    assign out_valid = s3_vld;
    assign out_pix   = s3_res[OUT_W-1:0];

    // R6: registered result stays inside the window it was clamped to.
    a_r6_out_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        s3_vld |-> (s3_res >= $signed({2'b00, $past(s2_lo)}) &&
                    s3_res <= $signed({{2{$past(s2_hi[SAMP_W-1])}}, $past(s2_hi)})));

    // Cycles since reset, saturating, used only to bound the latency check.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));
    a_r12_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_dering_pixel_filter.sv
module tb_dering_pixel_filter;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [15:0]   centre = '0;
    logic [63:0]   pri_taps = '0;
    logic [127:0]  sec_taps = '0;
    logic [7:0]    pri_str = '0;
    logic [7:0]    sec_str = '0;
    logic [3:0]    damping = '0;
    logic          out_valid;
    logic [7:0]    out_pix;

    int checks = 0;
    int fails  = 0;

    always #10ns clk = ~clk;

    dering_pixel_filter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .centre(centre),
        .pri_taps(pri_taps), .sec_taps(sec_taps), .pri_str(pri_str),
        .sec_str(sec_str), .damping(damping), .out_valid(out_valid),
        .out_pix(out_pix)
    );

    typedef struct packed {
        logic [15:0]       px;
        logic [7:0]        ps;
        logic [7:0]        ss;
        logic [3:0]        dm;
        logic [3:0][15:0]  pt;
        logic [7:0][15:0]  st;
        logic [7:0]        ex;
    } vec_t;

    localparam int NV = 16;
    // Tap lists are written from the highest slice down to slice 0.
    localparam vec_t TBL [NV] = '{
        '{16'd100, 8'd4,  8'd2, 4'd3, '{4{16'd100}}, '{8{16'd100}}, 8'd100},
        '{16'd100, 8'd4,  8'd2, 4'd6, '{4{16'd110}}, '{8{16'd100}}, 8'd103},
        '{16'd100, 8'd4,  8'd2, 4'd6, '{4{16'd90}},  '{8{16'd100}}, 8'd97},
        '{16'd100, 8'd0,  8'd4, 4'd6, '{4{16'd100}},
          '{16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd96}, 8'd99},
        '{16'd100, 8'd4,  8'd2, 4'd6, '{16'd100,16'd100,16'd120,16'h8000},
          '{8{16'd100}}, 8'd101},
        '{16'd100, 8'd8,  8'd8, 4'd6, '{4{16'd110}}, '{8{16'd110}}, 8'd110},
        '{16'd100, 8'd15, 8'd8, 4'd6, '{4{16'd110}},
          '{16'h8000,16'd110,16'd110,16'd110,16'd110,16'd110,16'd110,16'd110}, 8'd110},
        '{16'd100, 8'd15, 8'd8, 4'd6, '{4{16'd90}},
          '{16'h8000,16'd90,16'd90,16'd90,16'd90,16'd90,16'd90,16'd90}, 8'd90},
        '{16'd100, 8'd0,  8'd0, 4'd6, '{4{16'd120}}, '{8{16'd80}}, 8'd100},
        '{16'd100, 8'd15, 8'd0, 4'd2, '{4{16'd110}}, '{8{16'd100}}, 8'd104},
        '{16'd100, 8'd5,  8'd0, 4'd6, '{16'd110,16'd110,16'd100,16'd100},
          '{8{16'd100}}, 8'd102},
        '{16'd100, 8'd4,  8'd0, 4'd6, '{16'd110,16'd110,16'd100,16'd100},
          '{8{16'd100}}, 8'd101},
        '{16'd100, 8'd0,  8'd4, 4'd6, '{4{16'd100}},
          '{16'd100,16'd100,16'd100,16'd96,16'd100,16'd100,16'd100,16'd100}, 8'd100},
        '{16'd100, 8'd0,  8'd8, 4'd1, '{4{16'd100}},
          '{16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd105}, 8'd100},
        '{16'd100, 8'd0,  8'd4, 4'd6, '{4{16'd100}},
          '{16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd100,16'd104}, 8'd101},
        '{16'd291, 8'd0,  8'd0, 4'd6, '{4{16'd291}}, '{8{16'd291}}, 8'd35}
    };

    function automatic string tag(input int i);
        case (i)
            0:  return "R1 flat";
            1:  return "R1 R3 even primary";
            2:  return "R1 negative";
            3:  return "R4 R5 sum -8";
            4:  return "R9 padding tap";
            5:  return "R6 clamp high";
            6:  return "R8 padding vs max";
            7:  return "R7 padding vs min";
            8:  return "R10 zero strengths";
            9:  return "R2 primary shift floor";
            10: return "R3 odd round-1 weight";
            11: return "R3 even round-1 weight";
            12: return "R4 round-1 secondary";
            13: return "R2 secondary shift floor";
            14: return "R5 sum +8";
            default: return "R11 truncation";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        centre   = v.px;
        pri_str  = v.ps;
        sec_str  = v.ss;
        damping  = v.dm;
        pri_taps = v.pt;
        sec_taps = v.st;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20ns * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int lat;
        // R12: reset state.
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R12 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;

        // Table, streamed back to back; output k-3 observed at negedge k.
        for (int k = 0; k < NV + 3; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                check(out_valid == 1'b1, {tag(k-3), " valid"}, int'(out_valid), 1);
                check(out_pix == TBL[k-3].ex, tag(k-3), int'(out_pix), int'(TBL[k-3].ex));
            end
            if (k < NV) drive(TBL[k]);
            else        in_valid = 1'b0;
        end

        // R12: single pulse latency and width.
        @(negedge clk);
        drive(TBL[1]);
        lat = 0;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 3, "R12 latency", lat, 3);
        check(out_pix == 8'd103, "R12 pulse data", int'(out_pix), 103);
        @(negedge clk);
        check(out_valid == 1'b0, "R12 single pulse", int'(out_valid), 0);

        // R12: reset during a full pipeline clears the output.
        drive(TBL[0]);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R12 mid-stream reset", int'(out_valid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R12 idle after reset", int'(out_valid), 0);

        finish_run();
    end
endmodule